// File: doc/BRIEF.md
# Contact Image Sensor Line Sequencer

This block runs a linear contact image sensor that reads one colour at a time. The sensor has a clock input, a start input and three separately switched illumination LEDs (red, green and blue). The block makes a free-running sensor clock by dividing the system clock. It starts one sub-line per colour in the fixed order red, green, blue. It turns on the LED for the colour being read. During each sub-line it tells a downstream converter when to sample. A single-cycle strobe marks each reference-level clock period. A second single-cycle strobe marks each valid pixel period and comes with the colour code and the pixel index.

A sub-line always has the same layout. After the start pulse, the sensor gives the reference level for the first 64 sensor clocks. The next 864 clocks carry pixel data, and the rest of the sub-line is blank. With the default 1000-clock sub-line, 72 clocks are blank. The LED for the next colour is turned on at the start of that blank stretch. If `scan_en` is low when the blank stretch of the blue sub-line begins, the sequencer finishes that colour line and stops. Once stopped it keeps the start pulse low and all LEDs dark.

Top module: `cis_seq`

## Requirements
- R1: `sens_clk` is the system clock divided by 2*HALF_DIV with a 50% duty cycle: HALF_DIV system cycles high, then HALF_DIV low. It runs continuously from reset.
- R2: After reset, and for as long as `scan_en` stays low, `sens_start`, all LED enables, `pix_strobe`, `ref_strobe` and `pix_index` are 0.
- R3: `sens_start` changes level only in the system cycle where `sens_clk` falls. Each pulse lasts exactly one sensor clock period, so exactly one rising edge of `sens_clk` falls inside it. That rising edge begins sensor clock 1 of the sub-line.
- R4: For sensor clocks 1 to REF_CLKS (default 64) of a sub-line, `ref_strobe` is high for exactly one system cycle per clock period. That cycle is the first system cycle of the low half of `sens_clk`.
- R5: For sensor clocks REF_CLKS+1 to REF_CLKS+PIX_CNT, `pix_strobe` is high for exactly one system cycle, at the same point in the period. While it is high, `pix_index` equals the clock number minus REF_CLKS, so it runs from 1 to PIX_CNT (default 864).
- R6: In the blank clocks, from REF_CLKS+PIX_CNT+1 to LINE_CLKS, neither strobe is ever high.
- R7: A sub-line lasts LINE_CLKS sensor clocks (default 1000). While the sequencer is running, the next start pulse brackets the rising edge right after clock LINE_CLKS. No start pulse appears anywhere else inside a sub-line.
- R8: Sub-line colours follow the order red, green, blue, red, and so on. `pix_color` codes red as 0, green as 1 and blue as 2 and is valid with both strobes. From clock 1 to clock REF_CLKS+PIX_CNT exactly one LED is on, and it is the one for the current colour. The enables are `led_red`, `led_green` and `led_blue`.
- R9: At the first blank clock of a sub-line, the LED changes to the next colour in the order. The exception is the stop case in R10, where the LED goes dark instead.
- R10: `scan_en` is sampled once per colour line, at the start of the blue sub-line's blank stretch. If it is low, all LEDs turn off, no further start pulse is issued and the block goes idle. Lowering `scan_en` at any earlier point in the colour line does not stop it.
- R11: A scan that begins from idle always starts with a red sub-line. The red LED turns on together with the start pulse.
- R12: `pix_strobe` and `ref_strobe` are never high together. Neither is ever high while `sens_clk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Scan request; sampled at the blue sub-line's blank start, and when idle |
| sens_clk | output | 1 | Sensor clock, 50% duty |
| sens_start | output | 1 | Per-sub-line start pulse |
| led_red | output | 1 | Red LED enable |
| led_green | output | 1 | Green LED enable |
| led_blue | output | 1 | Blue LED enable |
| pix_strobe | output | 1 | One-cycle sample strobe for a valid pixel |
| ref_strobe | output | 1 | One-cycle sample strobe for a reference-level period |
| pix_color | output | 2 | Colour of the current sub-line (0 red, 1 green, 2 blue) |
| pix_index | output | $clog2(PIX_CNT+1) | Pixel number 1..PIX_CNT during pixel periods, else 0 |

## Verification
The hardest case to reach is the stop decision. `scan_en` has an effect only at one edge per colour line, and lowering it anywhere else must change nothing. The bench lowers `scan_en` during a red sub-line and checks that green and blue still run in full before the block goes dark. In a second scan it lowers `scan_en` early and raises it again during the blue reference stretch, which must give an uninterrupted run into the next red sub-line. A monitor counts sensor clocks independently from the start pulses it sees. From that count it predicts every strobe, index, colour and LED state in every system cycle.

// File: rtl/cis_seq_pkg.sv
`timescale 1ns/1ps
package cis_seq_pkg;

    localparam int unsigned DEF_HALF_DIV  = 4;
    localparam int unsigned DEF_REF_CLKS  = 64;
    localparam int unsigned DEF_PIX_CNT   = 864;
    localparam int unsigned DEF_LINE_CLKS = 1000;

    typedef enum logic [1:0] {
        CIS_RED   = 2'd0,
        CIS_GREEN = 2'd1,
        CIS_BLUE  = 2'd2
    } cis_color_e;

    // Phase markers of the divider, one system cycle wide each
    typedef struct packed {
        logic last;   // final cycle of the period: next edge raises sens_clk
        logic half;   // final high cycle: next edge lowers sens_clk
        logic mid;    // first low cycle: sampling point
    } cis_phase_t;

    function automatic cis_color_e cis_next_color(input cis_color_e c);
        case (c)
            CIS_RED:   return CIS_GREEN;
            CIS_GREEN: return CIS_BLUE;
            default:   return CIS_RED;
        endcase
    endfunction

    // LED vector ordered {blue, green, red}
    function automatic logic [2:0] cis_led_vec(input cis_color_e c, input logic on);
        logic [2:0] v;
        v = 3'b000;
        if (on) begin
            case (c)
                CIS_RED:   v = 3'b001;
                CIS_GREEN: v = 3'b010;
                default:   v = 3'b100;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/cis_clkdiv.sv
`timescale 1ns/1ps
module cis_clkdiv
    import cis_seq_pkg::*;
#(
    parameter int unsigned HALF_DIV = DEF_HALF_DIV
) (
    input  logic       clk,
    input  logic       rst,
    output logic       sclk,
    output cis_phase_t phase
);
    localparam int unsigned PERIOD = 2 * HALF_DIV;
    localparam int unsigned CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == CW'(PERIOD - 1))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CW'(1);
    end

    assign sclk       = (cnt_q < CW'(HALF_DIV));
    assign phase.last = (cnt_q == CW'(PERIOD - 1));
    assign phase.half = (cnt_q == CW'(HALF_DIV - 1));
    assign phase.mid  = (cnt_q == CW'(HALF_DIV));

    // R1: the clock is high right after every period wrap
    assert_wrap_high_R1: assert property (@(posedge clk) disable iff (rst)
        phase.last |=> sclk);

endmodule

// File: rtl/cis_line_fsm.sv
`timescale 1ns/1ps
module cis_line_fsm
    import cis_seq_pkg::*;
#(
    parameter int unsigned REF_CLKS  = DEF_REF_CLKS,
    parameter int unsigned PIX_CNT   = DEF_PIX_CNT,
    parameter int unsigned LINE_CLKS = DEF_LINE_CLKS,
    localparam int unsigned PW       = $clog2(LINE_CLKS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scan_en,
    input  cis_phase_t    phase,
    output logic [PW-1:0] pos,
    output cis_color_e    color,
    output logic          start,
    output logic [2:0]    leds
);
    localparam logic [PW-1:0] LAST_PIX = PW'(REF_CLKS + PIX_CNT);
    localparam logic [PW-1:0] LINE_END = PW'(LINE_CLKS);

    logic [PW-1:0] pos_q;
    cis_color_e    color_q;
    cis_color_e    led_sel_q;
    logic          sp_q;
    logic          cont_q;
    logic          led_on_q;

    logic idle, at_end, launch;

    assign idle   = (pos_q == '0);
    assign at_end = (pos_q == LINE_END);
    assign launch = (idle && scan_en) ||
                    (at_end && ((color_q != CIS_BLUE) || cont_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q     <= '0;
            color_q   <= CIS_RED;
            led_sel_q <= CIS_RED;
            sp_q      <= 1'b0;
            cont_q    <= 1'b0;
            led_on_q  <= 1'b0;
        end else begin
            // start pulse moves with the falling edge of the sensor clock
            if (phase.half) begin
                sp_q <= launch;
                if (idle && scan_en) begin
                    led_on_q  <= 1'b1;
                    led_sel_q <= CIS_RED;
                end
            end
            // clock counter moves with the rising edge
            if (phase.last) begin
                if (sp_q) begin
                    pos_q   <= PW'(1);
                    color_q <= idle ? CIS_RED : cis_next_color(color_q);
                end else if (idle || at_end) begin
                    pos_q <= '0;
                end else begin
                    pos_q <= pos_q + PW'(1);
                    if (pos_q == LAST_PIX) begin
                        led_sel_q <= cis_next_color(color_q);
                        if (color_q == CIS_BLUE) begin
                            cont_q   <= scan_en;
                            led_on_q <= scan_en;
                        end
                    end
                end
            end
        end
    end

    assign pos   = pos_q;
    assign color = color_q;
    assign start = sp_q;
    assign leds  = cis_led_vec(led_sel_q, led_on_q);

    // R2: dark whenever idle and no start is pending
    assert_dark_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (idle && !sp_q) |-> (leds == 3'b000));

    // R10: a line end without a start pulse leaves the block idle and dark
    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (phase.last && at_end && !sp_q) |=> (pos_q == '0 && leds == 3'b000));

    // R7: a new sub-line only begins out of idle or the last clock
    assert_start_at_end_R7: assert property (@(posedge clk) disable iff (rst)
        (phase.last && sp_q) |-> (idle || at_end));

endmodule

// File: rtl/cis_strobe_dec.sv
`timescale 1ns/1ps
module cis_strobe_dec
    import cis_seq_pkg::*;
#(
    parameter int unsigned REF_CLKS  = DEF_REF_CLKS,
    parameter int unsigned PIX_CNT   = DEF_PIX_CNT,
    parameter int unsigned PW        = 10,
    localparam int unsigned IW       = $clog2(PIX_CNT + 1)
) (
    input  logic [PW-1:0] pos,
    input  logic          mid,
    output logic          pix_stb,
    output logic          ref_stb,
    output logic [IW-1:0] index
);
    localparam logic [PW-1:0] REF_LAST = PW'(REF_CLKS);
    localparam logic [PW-1:0] PIX_LAST = PW'(REF_CLKS + PIX_CNT);

    logic in_ref, in_pix;
    logic [PW-1:0] offs;

    assign in_ref  = (pos != '0) && (pos <= REF_LAST);
    assign in_pix  = (pos > REF_LAST) && (pos <= PIX_LAST);
    assign offs    = pos - REF_LAST;

    assign ref_stb = mid && in_ref;
    assign pix_stb = mid && in_pix;
    assign index   = in_pix ? IW'(offs) : '0;

endmodule

// File: rtl/cis_seq.sv
`timescale 1ns/1ps
module cis_seq
    import cis_seq_pkg::*;
#(
    parameter int unsigned HALF_DIV  = DEF_HALF_DIV,
    parameter int unsigned REF_CLKS  = DEF_REF_CLKS,
    parameter int unsigned PIX_CNT   = DEF_PIX_CNT,
    parameter int unsigned LINE_CLKS = DEF_LINE_CLKS
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         scan_en,
    output logic                         sens_clk,
    output logic                         sens_start,
    output logic                         led_red,
    output logic                         led_green,
    output logic                         led_blue,
    output logic                         pix_strobe,
    output logic                         ref_strobe,
    output logic [1:0]                   pix_color,
    output logic [$clog2(PIX_CNT+1)-1:0] pix_index
);
    localparam int unsigned PW = $clog2(LINE_CLKS + 1);
    localparam logic [PW-1:0] PIX_LAST = PW'(REF_CLKS + PIX_CNT);

    cis_phase_t    phase;
    logic [PW-1:0] pos;
    cis_color_e    color;
    logic [2:0]    leds;

    cis_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk   (clk),
        .rst   (rst),
        .sclk  (sens_clk),
        .phase (phase)
    );

    cis_line_fsm #(
        .REF_CLKS  (REF_CLKS),
        .PIX_CNT   (PIX_CNT),
        .LINE_CLKS (LINE_CLKS)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .scan_en (scan_en),
        .phase   (phase),
        .pos     (pos),
        .color   (color),
        .start   (sens_start),
        .leds    (leds)
    );

    cis_strobe_dec #(
        .REF_CLKS (REF_CLKS),
        .PIX_CNT  (PIX_CNT),
        .PW       (PW)
    ) u_dec (
        .pos     (pos),
        .mid     (phase.mid),
        .pix_stb (pix_strobe),
        .ref_stb (ref_strobe),
        .index   (pix_index)
    );

    assign led_red   = leds[0];
    assign led_green = leds[1];
    assign led_blue  = leds[2];
    assign pix_color = color;

    assert_start_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(sens_start) |-> $fell(sens_clk));

    assert_led_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({led_blue, led_green, led_red}));

    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (rst)
        !(pix_strobe && ref_strobe));

    assert_strobe_low_R12: assert property (@(posedge clk) disable iff (rst)
        (pix_strobe || ref_strobe) |-> !sens_clk);

    assert_index_range_R5: assert property (@(posedge clk) disable iff (rst)
        pix_strobe |-> (pix_index != '0 && pix_index <= ($clog2(PIX_CNT+1))'(PIX_CNT)));

    assert_blank_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (pos > PIX_LAST) |-> !(pix_strobe || ref_strobe));

endmodule

// File: tb/cis_seq_test.sv
`timescale 1ns/1ps
module cis_seq_test;
    localparam int H    = 2;
    localparam int REF  = 64;
    localparam int PIX  = 864;
    localparam int LINE = 1000;
    localparam int IW   = $clog2(PIX + 1);
    localparam int SUB  = 2 * H * LINE;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scan_en = 1'b0;
    logic sclk, sp, lr, lg, lb, dv, rv;
    logic [1:0] col;
    logic [IW-1:0] idx;

    always #2 clk = ~clk;

    cis_seq #(.HALF_DIV(H), .REF_CLKS(REF), .PIX_CNT(PIX), .LINE_CLKS(LINE)) uut (
        .clk(clk), .rst(rst), .scan_en(scan_en),
        .sens_clk(sclk), .sens_start(sp),
        .led_red(lr), .led_green(lg), .led_blue(lb),
        .pix_strobe(dv), .ref_strobe(rv),
        .pix_color(col), .pix_index(idx)
    );

    int checks = 0;
    int errors = 0;

    // monitor state
    logic prev_sclk, sp_prev, rise, fall, mid, stop_flag;
    int lvl_len, edges, t, clkno, exp_col, sublines, dv_total, rv_total;
    int err_r1, err_r3, err_r4, err_r5, err_r6, err_r7, err_r8, err_r9, err_r10, err_r12;
    int colr [0:15];
    logic [2:0] exp_led, led_now;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            prev_sclk = sclk; sp_prev = sp; lvl_len = 0; edges = 0; t = 0;
            clkno = 0; exp_col = 0; stop_flag = 1'b0;
        end else begin
            rise = sclk && !prev_sclk;
            fall = !sclk && prev_sclk;
            if (rise || fall) begin
                if (edges >= 1 && lvl_len != H) err_r1++;
                edges++;
                lvl_len = 1;
            end else lvl_len++;
            if (sp != sp_prev && !fall) err_r3++;
            if (fall && sp_prev && sp) err_r3++;
            if (rise) begin
                t = 0;
                if (clkno == LINE) begin
                    if (stop_flag) begin if (sp) err_r10++; end
                    else if (!sp) err_r7++;
                end else if (sp && clkno != 0) err_r7++;
                if (sp) begin
                    exp_col = (clkno == 0) ? 0 : (exp_col + 1) % 3;
                    colr[sublines % 16] = exp_col;
                    sublines++;
                    clkno = 1;
                end else if (clkno == LINE) clkno = 0;
                else if (clkno != 0) clkno++;
                if (clkno == REF + PIX + 1) stop_flag = (exp_col == 2) && !scan_en;
            end else t++;
            mid = (t == H) && (clkno != 0);
            if (rv !== (mid && clkno >= 1 && clkno <= REF)) err_r4++;
            if (dv !== (mid && clkno > REF && clkno <= REF + PIX)) err_r5++;
            if (dv && int'(idx) != clkno - REF) err_r5++;
            if ((dv || rv) && int'(col) != exp_col) err_r8++;
            if (clkno > REF + PIX && (dv || rv)) err_r6++;
            if (dv && rv) err_r12++;
            if ((dv || rv) && sclk) err_r12++;
            if (dv) dv_total++;
            if (rv) rv_total++;
            if (clkno >= 1 && clkno <= REF + PIX) exp_led = 3'b001 << exp_col;
            else if (clkno > REF + PIX) exp_led = stop_flag ? 3'b000 : (3'b001 << ((exp_col + 1) % 3));
            else exp_led = sp ? 3'b001 : 3'b000;
            led_now = {lb, lg, lr};
            if (led_now !== exp_led) begin
                if (clkno > REF + PIX) err_r9++; else err_r8++;
            end
            sp_prev = sp;
            prev_sclk = sclk;
        end
    end

    task automatic wait_sub(input int target, input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (sublines >= target) break;
        end
    endtask

    task automatic drive_en(input logic v);
        @(negedge clk);
        #1 scan_en = v;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (5) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(sp == 1'b0, "R2 start after reset", sp, 0);
        check({lb, lg, lr} == 3'b000, "R2 leds after reset", {lb, lg, lr}, 0);
        check(!dv && !rv, "R2 strobes after reset", {dv, rv}, 0);
        check(idx == '0, "R2 index after reset", idx, 0);
    endtask

    task automatic t_idle;
        int seen;
        seen = 0;
        repeat (80 * H) begin
            @(negedge clk);
            if (sp || lr || lg || lb || dv || rv) seen++;
        end
        check(seen == 0, "R2 quiet while disabled", seen, 0);
        check(sublines == 0, "R2 no sub-line while disabled", sublines, 0);
    endtask

    task automatic t_scan;
        int s0, d0, r0;
        s0 = sublines; d0 = dv_total; r0 = rv_total;
        drive_en(1'b1);
        wait_sub(s0 + 4, 4 * SUB + 100);
        check(sublines == s0 + 4, "R7 sub-lines follow back to back", sublines, s0 + 4);
        check(dv_total - d0 == 3 * PIX, "R5 pixel strobes per colour line", dv_total - d0, 3 * PIX);
        check(rv_total - r0 == 3 * REF, "R4 reference strobes per colour line", rv_total - r0, 3 * REF);
        check(colr[s0 % 16] == 0, "R11 first colour red", colr[s0 % 16], 0);
        check(colr[(s0 + 1) % 16] == 1, "R8 second colour green", colr[(s0 + 1) % 16], 1);
        check(colr[(s0 + 2) % 16] == 2, "R8 third colour blue", colr[(s0 + 2) % 16], 2);
        check(colr[(s0 + 3) % 16] == 0, "R8 wrap to red", colr[(s0 + 3) % 16], 0);
    endtask

    task automatic t_stop;
        int s0, late;
        s0 = sublines;          // red sub-line in progress
        drive_en(1'b0);
        repeat (3 * SUB) @(negedge clk);
        check(sublines == s0 + 2, "R10 colour line completes after disable", sublines, s0 + 2);
        check(colr[(sublines - 1) % 16] == 2, "R10 last colour blue", colr[(sublines - 1) % 16], 2);
        check({lb, lg, lr} == 3'b000, "R10 leds dark when stopped", {lb, lg, lr}, 0);
        late = 0;
        repeat (SUB) begin
            @(negedge clk);
            if (sp || lr || lg || lb) late++;
        end
        check(late == 0, "R10 no activity after stop", late, 0);
        check(sublines == s0 + 2, "R10 no new sub-line after stop", sublines, s0 + 2);
    endtask

    task automatic t_restart_blip;
        int s0;
        s0 = sublines;
        drive_en(1'b1);
        wait_sub(s0 + 1, 4 * H + 10);
        check(sublines == s0 + 1, "R11 restart begins promptly", sublines, s0 + 1);
        check(colr[s0 % 16] == 0, "R11 restart colour red", colr[s0 % 16], 0);
        repeat (2 * H * 10) @(negedge clk);
        drive_en(1'b0);         // dropped during red
        wait_sub(s0 + 3, 3 * SUB);
        repeat (2 * H * 10) @(negedge clk);
        drive_en(1'b1);         // raised again in blue reference stretch
        wait_sub(s0 + 4, 2 * SUB);
        check(sublines == s0 + 4, "R10 re-enable before blue blank keeps running", sublines, s0 + 4);
        check(colr[(s0 + 3) % 16] == 0, "R8 next line red after blip", colr[(s0 + 3) % 16], 0);
    endtask

    task automatic t_totals;
        check(err_r1 == 0, "R1 sensor clock levels", err_r1, 0);
        check(err_r3 == 0, "R3 start pulse timing", err_r3, 0);
        check(err_r4 == 0, "R4 reference strobe placement", err_r4, 0);
        check(err_r5 == 0, "R5 pixel strobe and index", err_r5, 0);
        check(err_r6 == 0, "R6 blank stretch quiet", err_r6, 0);
        check(err_r7 == 0, "R7 sub-line length", err_r7, 0);
        check(err_r8 == 0, "R8 colour and LED match", err_r8, 0);
        check(err_r9 == 0, "R9 LED switch at blank", err_r9, 0);
        check(err_r10 == 0, "R10 stop behaviour", err_r10, 0);
        check(err_r12 == 0, "R12 strobe exclusivity", err_r12, 0);
    endtask

    initial begin
        t_reset;
        t_idle;
        t_scan;
        t_stop;
        t_restart_blip;
        t_totals;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule